// File: doc/BRIEF.md
# Double-Buffered PWM Generator with Fine-Delay Code

This block is one PWM channel with two outputs, A and B, driven from a shared up-counting time base. The counter runs from zero up to a period value and then returns to zero. Each output goes high at the start of a cycle and goes low when the counter reaches its compare value. The two compare values are written into shadow copies. The shadow copies move to the active copies only at the cycle boundary, so a compare update never splits a PWM cycle. The period value has no shadow copy and takes effect at once.

The compare A word packs two values. The upper half is the coarse compare count. The lower half is a fractional field whose upper byte is a fine step count. The fine count is committed together with the coarse value. It is exported as a code, with a one-cycle strobe, at each falling edge of A, so that an external sub-clock delay stage can shift that edge. A shared sync-enable input freezes the time base. Several channels tied to the same enable therefore start counting in the same cycle.

Software reaches the block through a single-cycle write port. The port has a register select and two half-word enables, so any register can be written as a full 32-bit word or as either 16-bit half.

Top module: `fine_pwm_core`

## Requirements
- R1: While `sync_en` is high, the counter advances by one each clock and returns to 0 on the clock after it reaches or exceeds the period value. A cycle therefore lasts period+1 clocks, and output A rises every period+1 clocks.
- R2: A period write takes effect for the counter from the next clock, with no wait for the cycle boundary.
- R3: Output A goes high on the clock after the counter is 0. It goes low on the clock after the counter equals the active coarse compare A, which gives a high time of exactly that many clocks.
- R4: Output B goes high on the clock after the counter is 0 and goes low on the clock after the counter equals active compare B.
- R5: Compare writes land in shadow registers. Active values change only at the start of a cycle, when the counter is 0. A write made during a cycle, including the last clock of that cycle, leaves the current cycle's waveform unchanged.
- R6: The register select `wr_sel` decodes 0 as period, 1 as compare A and 2 as compare B; the value 3 is ignored. The period and compare B take `wr_data[15:0]`. Compare A takes the coarse count from `wr_data[31:16]` and the fractional field from `wr_data[15:0]`. Only bits [15:8] of that field are kept, as the fine code.
- R7: `wr_hi` enables the upper half and `wr_lo` enables the lower half. Writing one half of compare A leaves the other half unchanged, and both halves are committed together at the cycle start.
- R8: While `sync_en` is low, the counter and both outputs hold their values and no output event occurs.
- R9: An active compare greater than the period keeps its output high for the whole cycle. A compare of 0 keeps its output low, because the clear wins over the set on the same count.
- R10: On each falling edge of A, `fine_code` takes the fine byte of the active compare A and `fine_stb` is high for that one clock. At all other times the code holds, and edges of B never strobe.
- R11: Reset clears the counter, all registers, both outputs, `fine_code` and `fine_stb` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Shared time-base run enable |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 period, 1 compare A, 2 compare B |
| wr_hi | input | 1 | Upper half-word enable |
| wr_lo | input | 1 | Lower half-word enable |
| wr_data | input | 32 | Write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| fine_code | output | 8 | Fine step count for the A falling edge |
| fine_stb | output | 1 | One-cycle strobe on each A falling edge |

## Verification
The bench targets several corner cases:
- A compare write in the middle of a cycle. A design that committed it at once would shorten or lengthen the current pulse.
- Half writes to compare A. A design that cleared the other half would corrupt the coarse count or the fine code.
- Compares beyond the period and compares of zero. A design that let the set win at zero would emit a one-clock glitch, and a wrong overflow test would clear an output that should stay high.
- Shortening the period while the counter is above the new value. A counter that wrapped only on equality would run through its full range.

The bench also drops `sync_en` in mid-cycle, where a design that still fired actions would move the outputs. It checks that the strobe tracks only A's falling edges and carries the committed fine byte rather than the shadow value.

// File: rtl/pwmf_pkg.sv
package pwmf_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_CMPA   = 2'd1,
        SEL_CMPB   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int NUM_OUT = 2;
    localparam int OUT_A   = 0;
    localparam int OUT_B   = 1;

endpackage

// File: rtl/pwmf_timebase.sv
module pwmf_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_next
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (run) begin
            if (s_q.cnt >= period) begin
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        zero_next = (s_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;

endmodule

// File: rtl/pwmf_regbank.sv
module pwmf_regbank
    import pwmf_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  cmpa_act,
    output logic [FINE_W-1:0] fine_act,
    output logic [CNT_W-1:0]  cmpb_act
);

    localparam int FINE_LSB = HALF_W - FINE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  prd;
        logic [CNT_W-1:0]  sh_a;
        logic [FINE_W-1:0] sh_f;
        logic [CNT_W-1:0]  sh_b;
        logic [CNT_W-1:0]  ac_a;
        logic [FINE_W-1:0] ac_f;
        logic [CNT_W-1:0]  ac_b;
    } rb_state_t;

    rb_state_t s_d, s_q;

    logic [HALF_W-1:0] lo_half;
    logic [HALF_W-1:0] hi_half;

    assign lo_half = wr_data[HALF_W-1:0];
    assign hi_half = wr_data[DATA_W-1:HALF_W];

    always_comb begin
        s_d = s_q;
        // commit uses the shadow values held before this cycle's write
        if (commit) begin
            s_d.ac_a = s_q.sh_a;
            s_d.ac_f = s_q.sh_f;
            s_d.ac_b = s_q.sh_b;
        end
        if (wr_en) begin
            unique case (wr_sel)
                SEL_PERIOD: begin
                    if (wr_lo) s_d.prd = lo_half[CNT_W-1:0];
                end
                SEL_CMPA: begin
                    if (wr_hi) s_d.sh_a = hi_half[CNT_W-1:0];
                    if (wr_lo) s_d.sh_f = lo_half[FINE_LSB +: FINE_W];
                end
                SEL_CMPB: begin
                    if (wr_lo) s_d.sh_b = lo_half[CNT_W-1:0];
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign period   = s_q.prd;
    assign cmpa_act = s_q.ac_a;
    assign fine_act = s_q.ac_f;
    assign cmpb_act = s_q.ac_b;

endmodule

// File: rtl/pwmf_edge_gen.sv
module pwmf_edge_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             out,
    output logic             fall_next
);

    typedef struct packed {
        logic lvl;
    } eg_state_t;

    eg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (run) begin
            if (cnt == '0) s_d.lvl = 1'b1;
            // the clear is evaluated last so it wins on a shared count
            if (cnt == cmp) s_d.lvl = 1'b0;
        end
        fall_next = s_q.lvl & ~s_d.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out = s_q.lvl;

endmodule

// File: rtl/pwmf_fine_tag.sv
module pwmf_fine_tag #(
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_next,
    input  logic [FINE_W-1:0] fine_act,
    output logic [FINE_W-1:0] code,
    output logic              stb
);

    typedef struct packed {
        logic [FINE_W-1:0] code;
        logic              stb;
    } ft_state_t;

    ft_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.stb = fall_next;
        if (fall_next) s_d.code = fine_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code = s_q.code;
    assign stb  = s_q.stb;

endmodule

// File: rtl/fine_pwm_core.sv
module fine_pwm_core
    import pwmf_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic [FINE_W-1:0] fine_code,
    output logic              fine_stb
);

    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  prd_w;
    logic              zero_next_w;
    logic [CNT_W-1:0]  cmpa_act_w;
    logic [CNT_W-1:0]  cmpb_act_w;
    logic [FINE_W-1:0] fine_act_w;
    reg_sel_e          sel_w;

    logic [NUM_OUT-1:0][CNT_W-1:0] cmp_vec;
    logic [NUM_OUT-1:0]            out_vec;
    logic [NUM_OUT-1:0]            fall_vec;

    assign sel_w = reg_sel_e'(wr_sel);

    pwmf_timebase #(.CNT_W(CNT_W)) tb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (sync_en),
        .period    (prd_w),
        .cnt       (cnt_w),
        .zero_next (zero_next_w)
    );

    pwmf_regbank #(.CNT_W(CNT_W), .FINE_W(FINE_W)) rb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (sel_w),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_data  (wr_data),
        .commit   (zero_next_w),
        .period   (prd_w),
        .cmpa_act (cmpa_act_w),
        .fine_act (fine_act_w),
        .cmpb_act (cmpb_act_w)
    );

    assign cmp_vec[OUT_A] = cmpa_act_w;
    assign cmp_vec[OUT_B] = cmpb_act_w;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_edge
        pwmf_edge_gen #(.CNT_W(CNT_W)) eg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (sync_en),
            .cnt       (cnt_w),
            .cmp       (cmp_vec[g]),
            .out       (out_vec[g]),
            .fall_next (fall_vec[g])
        );
    end

    pwmf_fine_tag #(.FINE_W(FINE_W)) ft_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_next (fall_vec[OUT_A]),
        .fine_act  (fine_act_w),
        .code      (fine_code),
        .stb       (fine_stb)
    );

    assign pwm_a = out_vec[OUT_A];
    assign pwm_b = out_vec[OUT_B];

endmodule

// File: rtl/pwmf_checker.sv
module pwmf_checker #(
    parameter int CNT_W  = 16,
    parameter int FINE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_en,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              wr_lo,
    input logic [31:0]       wr_data,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  prd,
    input logic [CNT_W-1:0]  act_b,
    input logic              pwm_a,
    input logic              pwm_b,
    input logic [FINE_W-1:0] fine_code,
    input logic              fine_stb
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && cnt < prd) |=> cnt == $past(cnt) + ONE); // R1

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && cnt >= prd) |=> cnt == '0); // R1

    AST_PRD_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_lo) |=> prd == $past(wr_data[CNT_W-1:0])); // R2

    AST_COMMIT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_b) |-> cnt == '0); // R5

    AST_HOLD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> $stable(cnt)); // R8

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> ($stable(pwm_a) && $stable(pwm_b))); // R8

    AST_STB_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fine_stb |-> $fell(pwm_a)); // R10

    AST_FALL_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_a) |-> fine_stb); // R10

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fine_stb |-> $stable(fine_code)); // R10

endmodule

bind fine_pwm_core pwmf_checker #(.CNT_W(CNT_W), .FINE_W(FINE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_en   (sync_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_lo     (wr_lo),
    .wr_data   (wr_data),
    .cnt       (cnt_w),
    .prd       (prd_w),
    .act_b     (cmpb_act_w),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .fine_code (fine_code),
    .fine_stb  (fine_stb)
);

// File: tb/fine_pwm_core_tb_top.sv
module fine_pwm_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic        wr_hi = 1'b0;
    logic        wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pwm_a, pwm_b, fine_stb;
    logic [7:0]  fine_code;

    always #5 clk = ~clk;

    fine_pwm_core dut_i (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .fine_code(fine_code), .fine_stb(fine_stb)
    );

    int    vecs = 0;
    int    errs = 0;
    string phase = "R11";

    // behavioural reference state
    int m_cnt, m_prd, m_sha, m_shf, m_shb, m_aca, m_acf, m_acb;
    int m_fc;
    bit m_a, m_b, m_fs;

    always @(posedge clk) begin : model
        int  ncnt;
        bit  na, nb;
        if (!rst_n) begin
            m_cnt = 0; m_prd = 0; m_sha = 0; m_shf = 0; m_shb = 0;
            m_aca = 0; m_acf = 0; m_acb = 0; m_fc = 0;
            m_a = 0; m_b = 0; m_fs = 0;
        end else begin
            ncnt = m_cnt;
            if (sync_en) ncnt = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
            na = m_a;
            nb = m_b;
            if (sync_en) begin
                if (m_cnt == 0) begin na = 1; nb = 1; end
                if (m_cnt == m_aca) na = 0;
                if (m_cnt == m_acb) nb = 0;
            end
            m_fs = m_a && !na;
            if (m_fs) m_fc = m_acf;
            if (ncnt == 0) begin
                m_aca = m_sha; m_acf = m_shf; m_acb = m_shb;
            end
            if (wr_en) begin
                if (wr_sel == 2'd0 && wr_lo) m_prd = int'(wr_data & 32'hFFFF);
                if (wr_sel == 2'd1 && wr_hi) m_sha = int'(wr_data >> 16);
                if (wr_sel == 2'd1 && wr_lo) m_shf = int'((wr_data >> 8) & 32'hFF);
                if (wr_sel == 2'd2 && wr_lo) m_shb = int'(wr_data & 32'hFFFF);
            end
            m_cnt = ncnt;
            m_a = na;
            m_b = nb;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s (phase %s) %s: actual=%0d expected=%0d", tag, phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(pwm_a == m_a, "R3", "pwm_a", int'(pwm_a), int'(m_a));
            check(pwm_b == m_b, "R4", "pwm_b", int'(pwm_b), int'(m_b));
            check(fine_stb == m_fs, "R10", "fine_stb", int'(fine_stb), int'(m_fs));
            check(int'(fine_code) == m_fc, "R10", "fine_code", int'(fine_code), m_fc);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input bit hi, input bit lo, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_hi = hi; wr_lo = lo; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
    endtask

    task automatic rise_gap(output int gap);
        bit prev;
        bit seen;
        gap = -1;
        seen = 0;
        prev = pwm_a;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (seen) gap++;
            if (!prev && pwm_a) begin
                if (seen) break;
                seen = 1;
                gap = 0;
            end
            prev = pwm_a;
        end
    endtask

    task automatic wait_stb();
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (fine_stb) break;
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin : stim
        int g;
        bit all_hi, all_lo;
        idle(3);
        // R11: outputs cleared in reset
        check(pwm_a == 0 && pwm_b == 0, "R11", "outputs in reset", int'({pwm_a, pwm_b}), 0);
        check(fine_code == 0 && fine_stb == 0, "R11", "fine in reset", int'(fine_code), 0);
        rst_n = 1'b1;

        phase = "R8";
        wr(2'd0, 0, 1, 32'd9);
        wr(2'd1, 1, 1, {16'd4, 16'h3700});
        wr(2'd2, 0, 1, 32'd7);
        idle(5);
        check(pwm_a == 0 && pwm_b == 0, "R8", "held before enable", int'({pwm_a, pwm_b}), 0);

        phase = "R3";
        sync_en = 1'b1;
        idle(30);
        rise_gap(g);
        check(g == 10, "R1", "A rise spacing", g, 10);

        phase = "R7";
        wr(2'd1, 1, 0, {16'd6, 16'hFFFF});
        idle(25);
        wait_stb();
        check(fine_code == 8'h37, "R7", "fine kept over hi write", int'(fine_code), 'h37);
        wr(2'd1, 0, 1, {16'd99, 16'h9C80});
        idle(25);
        wait_stb();
        check(fine_code == 8'h9C, "R6", "fine from bits 15:8", int'(fine_code), 'h9C);
        wr(2'd3, 1, 1, 32'h0001_0001);
        idle(12);

        phase = "R5";
        idle(3);
        wr(2'd2, 0, 1, 32'd2);
        idle(30);

        phase = "R9";
        wr(2'd1, 1, 0, {16'd20, 16'd0});
        wr(2'd2, 0, 1, 32'd0);
        idle(30);
        all_hi = 1; all_lo = 1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!pwm_a) all_hi = 0;
            if (pwm_b) all_lo = 0;
        end
        check(all_hi, "R9", "A high when compare beyond period", int'(all_hi), 1);
        check(all_lo, "R9", "B low when compare zero", int'(all_lo), 1);

        phase = "R2";
        wr(2'd1, 1, 0, {16'd5, 16'd0});
        wr(2'd2, 0, 1, 32'd3);
        idle(20);
        wr(2'd0, 0, 1, 32'd5);
        rise_gap(g);
        check(g == 6, "R2", "A rise spacing after period write", g, 6);
        idle(8);
        wr(2'd0, 0, 1, 32'd2);
        idle(20);
        wr(2'd0, 0, 1, 32'd9);
        idle(20);

        phase = "R8";
        sync_en = 1'b0;
        idle(10);
        sync_en = 1'b1;
        idle(20);

        phase = "R10";
        wr(2'd1, 1, 1, {16'd7, 16'h5A00});
        wr(2'd2, 0, 1, 32'd3);
        idle(40);

        phase = "R11";
        rst_n = 1'b0;
        idle(2);
        check(pwm_a == 0 && pwm_b == 0 && fine_code == 0, "R11", "outputs after reset",
              int'({pwm_a, pwm_b}), 0);
        rst_n = 1'b1;
        idle(10);

        summary();
        $finish;
    end

endmodule